// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block is a watchdog counter that advances on a slow clock enable and fires after a programmable number of ticks. Software sets it up through one 8-bit control register. That register holds a pending-interrupt flag, an interrupt enable, a reset enable, a change-window indicator and a 4-bit period select. The period select is split across bits 5 and 2..0.

On expiry the block either raises an interrupt, requests a system reset, or does both in turn. In the combined mode the first expiry only raises the interrupt. When the CPU takes the vector, the hardware drops the interrupt enable, so the next expiry becomes a reset request. A kick input restarts the count.

Changing the period or dropping the reset enable is guarded. Software must first open a short window, and only a write inside that window may make these changes.

Top module: `wdog_irq_timer`

## Requirements
- R1: After the synchronous reset, the control register reads 0x00, `irq` is 0 and `sys_rst_req` is 0. The exception is when `wd_was_cause` is 1 during reset: the register then reads 0x08, with the reset enable at bit 3 set.
- R2: Register layout: bit 7 is the flag, bit 6 the interrupt enable, bit 3 the reset enable, and bits 5 and 2..0 the period select N. With bit 6 set, the flag is set at the edge of the tick that completes 2^(BASE_LOG2+N) ticks. BASE_LOG2 defaults to 11.
- R3: `irq` is 1 only while the flag, bit 6 and `cpu_ie` are all 1.
- R4: A pulse on `irq_ack` clears the flag. If bit 3 is clear, bit 6 stays set.
- R5: A write with bit 7 set clears the flag. A write with bit 7 clear leaves the flag unchanged.
- R6: With bit 3 set and bit 6 clear, an expiry drives `sys_rst_req` high for exactly one cycle, and the flag stays clear.
- R7: With bits 6 and 3 both set, the first expiry sets only the flag and requests no reset. `irq_ack` then clears both bit 7 and bit 6, and the next expiry requests a reset.
- R8: A pulse on `kick` restarts the count from zero. Every expiry also restarts the count.
- R9: Select values 10 to 15 give the same period as 9.
- R10: Outside the window, a write cannot change the period select and cannot clear bit 3. A write with bits 4 and 3 both set opens the window, and bit 4 reads 1 while it is open. The next write then applies the new select and the new bit 3, and closes the window.
- R11: The window accepts a protected write only in the 4 clock cycles that follow the opening write. After that, bit 4 reads 0 and the protected fields keep their values.
- R12: A plain write may set bit 3 and may set or clear bit 6 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_was_cause | input | 1 | Reset-cause indication: last reset came from the watchdog |
| tick_en | input | 1 | Slow clock enable that advances the count |
| kick | input | 1 | Restart the count |
| bus_wr | input | 1 | Control register write strobe |
| bus_wdata | input | 8 | Control register write data |
| bus_rdata | output | 8 | Control register read value |
| cpu_ie | input | 1 | Global interrupt enable from the CPU |
| irq_ack | input | 1 | CPU has taken the watchdog vector |
| irq | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench counts expiry boundaries to the exact tick, one tick short and then on the boundary. A counter off by one, or a kick that failed to restart the count, would set the flag a tick early or late.

In the combined mode it checks that the first expiry gives no reset and that acknowledging the interrupt removes the enable. A design that reset at once, or kept the enable, would fail there.

For the guarded fields it probes the window on its last accepted cycle and on the first rejected one. It also tries a select of 12 to catch a missing clamp, which would otherwise read as a much longer period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned CTL_W = 8;

    typedef struct packed {
        logic       flag;
        logic       ien;
        logic       sel_hi;
        logic       win;
        logic       ren;
        logic [2:0] sel_lo;
    } wdog_ctl_t;

    function automatic logic [3:0] clamp_sel(input logic [3:0] s, input int unsigned mx);
        logic [3:0] lim;
        lim = mx[3:0];
        return (s > lim) ? lim : s;
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned BASE_LOG2 = 11,
    parameter int unsigned SEL_MAX   = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       kick,
    input  logic [3:0] sel,
    output logic       tmo
);
    import wdog_pkg::*;

    localparam int unsigned CNT_W = BASE_LOG2 + SEL_MAX;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   last;
    logic [3:0]       eff;

    always_comb begin
        eff  = clamp_sel(sel, SEL_MAX);
        span = {{CNT_W{1'b0}}, 1'b1} << (BASE_LOG2 + 32'(eff));
        last = span - 1'b1;
        tmo  = tick && !kick && ({1'b0, cnt} >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || kick || tmo) cnt <= '0;
        else if (tick)          cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
    parameter int unsigned WIN_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_cause,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       tmo,
    input  logic       ack,
    output logic       flag,
    output logic       ien,
    output logic       ren,
    output logic       win_open,
    output logic [3:0] sel
);
    import wdog_pkg::*;

    localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);

    logic [WIN_W-1:0] win_cnt;
    wdog_ctl_t        wd;

    assign wd       = wdog_ctl_t'(wdata);
    assign win_open = (win_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            ien     <= 1'b0;
            ren     <= wd_cause;
            sel     <= '0;
            win_cnt <= '0;
        end else begin
            if (wr) begin
                if (wd.flag) flag <= 1'b0;
                ien <= wd.ien;
                if (win_open) begin
                    sel     <= {wd.sel_hi, wd.sel_lo};
                    ren     <= wd.ren;
                    win_cnt <= '0;
                end else if (wd.win && wd.ren) begin
                    ren     <= 1'b1;
                    win_cnt <= WIN_W'(WIN_CYC);
                end else begin
                    ren <= ren | wd.ren;
                end
            end else if (win_open) begin
                win_cnt <= win_cnt - 1'b1;
            end
            if (ack) begin
                flag <= 1'b0;
                if (ren) ien <= 1'b0;
            end
            if (tmo && ien) flag <= 1'b1;
        end
    end

endmodule

// File: rtl/wdog_irq_timer.sv
module wdog_irq_timer #(
    parameter int unsigned BASE_LOG2 = 11,
    parameter int unsigned SEL_MAX   = 9,
    parameter int unsigned WIN_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_was_cause,
    input  logic       tick_en,
    input  logic       kick,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cpu_ie,
    input  logic       irq_ack,
    output logic       irq,
    output logic       sys_rst_req
);
    import wdog_pkg::*;

    logic       tmo_pulse;
    logic       flag_q, ien_q, ren_q, win_q;
    logic [3:0] sel_q;
    wdog_ctl_t  view;

    wdog_counter #(.BASE_LOG2(BASE_LOG2), .SEL_MAX(SEL_MAX)) u_cnt (
        .clk (clk),
        .rst (rst),
        .tick(tick_en),
        .kick(kick),
        .sel (sel_q),
        .tmo (tmo_pulse)
    );

    wdog_ctrl #(.WIN_CYC(WIN_CYC)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wd_cause(wd_was_cause),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .tmo     (tmo_pulse),
        .ack     (irq_ack),
        .flag    (flag_q),
        .ien     (ien_q),
        .ren     (ren_q),
        .win_open(win_q),
        .sel     (sel_q)
    );

    always_comb begin
        view.flag   = flag_q;
        view.ien    = ien_q;
        view.sel_hi = sel_q[3];
        view.win    = win_q;
        view.ren    = ren_q;
        view.sel_lo = sel_q[2:0];
        bus_rdata   = view;
        irq         = flag_q && ien_q && cpu_ie;
    end

    always_ff @(posedge clk) begin
        if (rst) sys_rst_req <= 1'b0;
        else     sys_rst_req <= tmo_pulse && ren_q && !ien_q;
    end

endmodule

// File: rtl/wdog_irq_timer_chk.sv
module wdog_irq_timer_chk #(
    parameter int unsigned WIN_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic irq,
    input logic irq_ack,
    input logic cpu_ie,
    input logic flag,
    input logic ien,
    input logic win,
    input logic sys_rst_req,
    input logic tmo
);
    logic [7:0] open_run;

    always_ff @(posedge clk) begin
        if (rst)      open_run <= '0;
        else if (win) open_run <= open_run + 1'b1;
        else          open_run <= '0;
    end

    a_r2_flag_on_expiry: assert property (@(posedge clk) disable iff (rst)
        tmo && ien |=> flag);

    a_r3_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !cpu_ie |-> !irq);

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        irq_ack && !tmo |=> !flag);

    a_r6_reset_one_cycle: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);

    a_r7_no_reset_with_ien: assert property (@(posedge clk) disable iff (rst)
        tmo && ien |=> !sys_rst_req);

    a_r11_window_bound: assert property (@(posedge clk) disable iff (rst)
        open_run <= 8'(WIN_CYC));

endmodule

bind wdog_irq_timer wdog_irq_timer_chk #(.WIN_CYC(WIN_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq        (irq),
    .irq_ack    (irq_ack),
    .cpu_ie     (cpu_ie),
    .flag       (bus_rdata[7]),
    .ien        (bus_rdata[6]),
    .win        (bus_rdata[4]),
    .sys_rst_req(sys_rst_req),
    .tmo        (tmo_pulse)
);

// File: tb/tb_wdog_irq_timer.sv
module tb_wdog_irq_timer;

    localparam int unsigned BASE = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_was_cause = 1'b0;
    logic       tick_en = 1'b0;
    logic       kick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_ie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       sys_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wdog_irq_timer #(.BASE_LOG2(BASE)) dut (
        .clk(clk), .rst(rst), .wd_was_cause(wd_was_cause), .tick_en(tick_en),
        .kick(kick), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_ie(cpu_ie), .irq_ack(irq_ack), .irq(irq), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic cause);
        wd_was_cause = cause;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic pulse_kick();
        kick = 1'b1; @(negedge clk); kick = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        chk("R1 cause reset reg", bus_rdata, 8'h08);
        do_reset(1'b0);
        chk("R1 plain reset reg", bus_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 rst_req", {7'd0, sys_rst_req}, 8'd0);
    endtask

    task automatic t_int_only();
        cpu_ie = 1'b1;
        wr(8'h40);
        chk("R12 set ien", bus_rdata, 8'h40);
        pulse_kick();
        ticks(7);
        chk("R2 not yet", bus_rdata, 8'h40);
        ticks(1);
        chk("R2 flag at 8 ticks", bus_rdata, 8'hC0);
        chk("R3 irq high", {7'd0, irq}, 8'd1);
        chk("R2 no reset", {7'd0, sys_rst_req}, 8'd0);
        cpu_ie = 1'b0; #1;
        chk("R3 irq gated", {7'd0, irq}, 8'd0);
        cpu_ie = 1'b1;
        pulse_ack();
        chk("R4 ack keeps ien", bus_rdata, 8'h40);
        ticks(8);
        chk("R8 expiry restarts count", bus_rdata, 8'hC0);
        wr(8'h40);
        chk("R5 write zero keeps flag", bus_rdata, 8'hC0);
        wr(8'hC0);
        chk("R5 write one clears flag", bus_rdata, 8'h40);
    endtask

    task automatic t_kick();
        pulse_kick();
        ticks(6);
        pulse_kick();
        ticks(7);
        chk("R8 kick restarted", bus_rdata, 8'h40);
        ticks(1);
        chk("R8 expiry after kick", bus_rdata, 8'hC0);
        wr(8'h80);
        chk("R12 clear ien", bus_rdata, 8'h00);
    endtask

    task automatic t_rst_only();
        wr(8'h08);
        chk("R12 set ren", bus_rdata, 8'h08);
        pulse_kick();
        ticks(7);
        chk("R6 no early reset", {7'd0, sys_rst_req}, 8'd0);
        ticks(1);
        chk("R6 reset pulse", {7'd0, sys_rst_req}, 8'd1);
        chk("R6 flag clear", bus_rdata, 8'h08);
        idle(1);
        chk("R6 pulse one cycle", {7'd0, sys_rst_req}, 8'd0);
    endtask

    task automatic t_combined();
        wr(8'h48);
        pulse_kick();
        ticks(8);
        chk("R7 first expiry flag", bus_rdata, 8'hC8);
        chk("R7 first expiry no reset", {7'd0, sys_rst_req}, 8'd0);
        pulse_ack();
        chk("R7 ack drops ien", bus_rdata, 8'h08);
        ticks(8);
        chk("R7 second expiry resets", {7'd0, sys_rst_req}, 8'd1);
    endtask

    task automatic t_window();
        wr(8'h01);
        chk("R10 unguarded write ignored", bus_rdata, 8'h08);
        wr(8'h18);
        chk("R10 window open", bus_rdata, 8'h18);
        wr(8'h01);
        chk("R10 guarded write applied", bus_rdata, 8'h01);
        wr(8'h41);
        pulse_kick();
        ticks(15);
        chk("R9 select 1 not yet", bus_rdata, 8'h41);
        ticks(1);
        chk("R9 select 1 period", bus_rdata, 8'hC1);
        wr(8'h80);
        wr(8'h18);
        idle(4);
        chk("R11 window closed", bus_rdata, 8'h09);
        wr(8'h02);
        chk("R11 late write ignored", bus_rdata, 8'h09);
        wr(8'h18);
        idle(3);
        wr(8'h00);
        chk("R11 last window cycle", bus_rdata, 8'h00);
        wr(8'h18);
        wr(8'h24);
        chk("R9 select 12 stored", bus_rdata, 8'h24);
        wr(8'h40);
        pulse_kick();
        ticks(4095);
        chk("R9 clamp not yet", bus_rdata, 8'h64);
        ticks(1);
        chk("R9 clamp period", bus_rdata, 8'hE4);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_int_only();
        t_kick();
        t_rst_only();
        t_combined();
        t_window();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule